// File: doc/BRIEF.md
# Segmented Byte-Lane Memory Sequencer

This block takes read and write requests that each carry a 16-bit segment value and a 16-bit offset. It forms a 20-bit physical address by shifting the segment four places left and adding the offset. It then runs the transfer over an 8-bit memory port that shares its low address lines with data. A 16-bit transfer is split into two byte cycles. The less significant byte goes to or comes from the lower address. A single-byte transfer uses one byte cycle.

Each byte cycle lasts three clocks. The first clock presents the address with an address-latch pulse. The second clock asserts the read or write strobe. The third clock leaves the bus quiet. The request side uses a valid/ready handshake. A completion pulse marks the last clock of every transfer. A read completes with the assembled 16-bit word.

Top module: `seg_byte_sequencer`

## Requirements
- R1: The first byte cycle presents the address ((segment << 4) + offset) mod 2^20. For example, segment A000h with offset 5F00h gives A5F00h, and segment FFFFh with offset 0010h gives 00000h.
- R2: A word transfer makes exactly two byte cycles, at address P and then at address (P + 1) mod 2^20. P = FFFFFh is therefore followed by 00000h.
- R3: A word write drives req_wdata[7:0] on the data lines in the cycle at P, and req_wdata[15:8] in the cycle at P + 1.
- R4: A word read returns the byte read at P in rsp_rdata[7:0] and the byte read at P + 1 in rsp_rdata[15:8]. A byte read returns its byte in rsp_rdata[7:0] with rsp_rdata[15:8] = 0.
- R5: A byte transfer (req_word = 0) makes exactly one byte cycle. A byte write drives req_wdata[7:0] and ignores req_wdata[15:8].
- R6: Every byte cycle takes three clocks: mem_ale = 1 in the first, mem_rd (read) or mem_wr (write) = 1 in the second, and all three low in the third. mem_ale, mem_rd and mem_wr are never high together in any pair.
- R7: req_ready is high only while idle. It falls in the clock after acceptance and stays low until the last byte cycle completes. Request fields that change while busy have no effect on the transfer in progress.
- R8: rsp_done is high for exactly one clock, the third clock of the last byte cycle, for reads and writes alike. For a read, rsp_rdata holds the result in that clock. req_ready is high in the next clock.
- R9: After reset, req_ready = 1 and mem_ale, mem_rd, mem_wr and rsp_done are all 0.
- R10: mem_addr holds the same value during all three clocks of a byte cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte transfer |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within the segment |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid with rsp_done on reads |
| mem_addr | output | 20 | Physical byte address |
| mem_ale | output | 1 | Address-latch pulse, first clock of a byte cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte driven during a write strobe |
| mem_rdata | input | 8 | Byte returned by memory, sampled at the end of the read strobe |

## Verification
The bench builds the block with its default parameters: a 16-bit segment and a 16-bit offset, a 4-bit shift, a 20-bit physical address and two 8-bit lanes per word. With these values, the top of the 1 MB space is reached in two ways. A base of FFFFFh forces the second byte address to wrap to zero. A segment/offset sum past 2^20 forces the carry to be dropped. A behavioural byte array decides every read value and records every write. The bus is compared with it on every clock, which exposes any swap of lanes, address or phase order. Request fields are also changed while a transfer is under way, to show that they are ignored.

// File: rtl/seg_seq_pkg.sv
package seg_seq_pkg;

   // Phase of the byte-cycle sequencer
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_STRB = 2'd2,
      PH_HOLD = 2'd3
   } phase_t;

endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   parameter int PA_W  = 20
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  phys
);

   localparam int SHIFTED_W = SEG_W + SHIFT;

   generate
      if (PA_W < SHIFTED_W || PA_W < OFF_W) begin : g_bad_width
         $error("seg_addr_gen: PA_W must cover shifted segment and offset");
      end
   endgenerate

   logic [SHIFTED_W-1:0] seg_shifted;

   always_comb begin
      seg_shifted = {seg, {SHIFT{1'b0}}};
      // sum is taken in PA_W bits so the carry past the top bit is dropped
      phys = PA_W'(seg_shifted) + PA_W'(off);
   end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import seg_seq_pkg::*;
#(
   parameter int NBYTES = 2,
   localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_word,
   input  logic          is_write,
   output logic [IW-1:0] idx,
   output logic          ready,
   output logic          ale,
   output logic          rd,
   output logic          wr,
   output logic          done,
   output logic          cap_en,
   output logic          step
);

   generate
      if (NBYTES < 1) begin : g_bad_nbytes
         $error("seq_ctrl: NBYTES must be at least 1");
      end
   endgenerate

   localparam logic [IW-1:0] LAST_WORD = IW'(NBYTES - 1);

   phase_t        phase_q;
   logic [IW-1:0] idx_q;
   logic [IW-1:0] last_q;
   logic          wr_q;
   logic          last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         last_q  <= '0;
         wr_q    <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q <= PH_ADDR;
                  idx_q   <= '0;
                  last_q  <= is_word ? LAST_WORD : '0;
                  wr_q    <= is_write;
               end
            end
            PH_ADDR: phase_q <= PH_STRB;
            PH_STRB: phase_q <= PH_HOLD;
            PH_HOLD: begin
               if (last) begin
                  phase_q <= PH_IDLE;
               end else begin
                  phase_q <= PH_ADDR;
                  idx_q   <= idx_q + IW'(1);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      last   = (idx_q == last_q);
      idx    = idx_q;
      ready  = (phase_q == PH_IDLE);
      ale    = (phase_q == PH_ADDR);
      rd     = (phase_q == PH_STRB) && !wr_q;
      wr     = (phase_q == PH_STRB) && wr_q;
      done   = (phase_q == PH_HOLD) && last;
      cap_en = (phase_q == PH_STRB) && !wr_q;
      step   = (phase_q == PH_HOLD) && !last;
   end

   // R6: strobes and latch pulse are mutually exclusive
   p_bus_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ale && (rd || wr)) && !(rd && wr));

   // R6: a strobe follows every latch pulse
   p_strobe_after_ale_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (rd || wr));

   // R6: the strobe lasts a single clock
   p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd || wr) |=> !(rd || wr || ale));

   // R7: ready drops once a request is taken
   p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ready);

   // R8: completion is a single clock and is followed by idle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && ready));

   // R8: completion comes right after a strobe clock
   p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rd || wr));

endmodule

// File: rtl/lane_pack.sv
module lane_pack #(
   parameter int LANE_W = 8,
   parameter int NBYTES = 2,
   localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1,
   localparam int WORD_W = LANE_W * NBYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] wdata_in,
   input  logic [IW-1:0]     idx,
   input  logic              cap_en,
   input  logic [LANE_W-1:0] rd_byte,
   output logic [LANE_W-1:0] wr_byte,
   output logic [WORD_W-1:0] rword
);

   logic [WORD_W-1:0] wreg_q;
   logic [LANE_W-1:0] wlane [NBYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wreg_q <= '0;
      end else if (start) begin
         wreg_q <= wdata_in;
      end
   end

   genvar g;
   generate
      for (g = 0; g < NBYTES; g++) begin : g_lane
         logic [LANE_W-1:0] rlane_q;

         assign wlane[g] = wreg_q[g*LANE_W +: LANE_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rlane_q <= '0;
            end else if (start) begin
               rlane_q <= '0;
            end else if (cap_en && (idx == IW'(g))) begin
               rlane_q <= rd_byte;
            end
         end

         assign rword[g*LANE_W +: LANE_W] = rlane_q;
      end
   endgenerate

   assign wr_byte = wlane[idx];

endmodule

// File: rtl/seg_byte_sequencer.sv
module seg_byte_sequencer #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int PA_W   = 20,
   parameter int LANE_W = 8,
   parameter int NBYTES = 2,
   localparam int WORD_W = LANE_W * NBYTES,
   localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic [PA_W-1:0]   mem_addr,
   output logic              mem_ale,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [LANE_W-1:0] mem_wdata,
   input  logic [LANE_W-1:0] mem_rdata
);

   logic            start;
   logic [PA_W-1:0] phys;
   logic [PA_W-1:0] addr_q;
   logic [IW-1:0]   idx;
   logic            cap_en;
   logic            step;

   assign start = req_valid && req_ready;

   seg_addr_gen #(
      .SEG_W (SEG_W),
      .OFF_W (OFF_W),
      .SHIFT (SHIFT),
      .PA_W  (PA_W)
   ) u_addr (
      .seg  (req_seg),
      .off  (req_off),
      .phys (phys)
   );

   seq_ctrl #(
      .NBYTES (NBYTES)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_word  (req_word),
      .is_write (req_write),
      .idx      (idx),
      .ready    (req_ready),
      .ale      (mem_ale),
      .rd       (mem_rd),
      .wr       (mem_wr),
      .done     (rsp_done),
      .cap_en   (cap_en),
      .step     (step)
   );

   lane_pack #(
      .LANE_W (LANE_W),
      .NBYTES (NBYTES)
   ) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .wdata_in (req_wdata),
      .idx      (idx),
      .cap_en   (cap_en),
      .rd_byte  (mem_rdata),
      .wr_byte  (mem_wdata),
      .rword    (rsp_rdata)
   );

   // address register: loaded on acceptance, stepped by one per extra byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (start) begin
         addr_q <= phys;
      end else if (step) begin
         addr_q <= addr_q + PA_W'(1);
      end
   end

   assign mem_addr = addr_q;

   // R10: address held through the strobe and quiet clocks
   p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ale || mem_rd || mem_wr) |=> $stable(mem_addr));

   // R2: a later byte cycle sits one address above the previous one
   p_next_byte_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ale && (idx != '0)) |-> (mem_addr == PA_W'($past(mem_addr, 3) + PA_W'(1))));

endmodule

// File: tb/seg_byte_sequencer_bench.sv
module seg_byte_sequencer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic [15:0] req_seg = '0;
   logic [15:0] req_off = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic [19:0] mem_addr;
   logic        mem_ale;
   logic        mem_rd;
   logic        mem_wr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;
   logic [7:0] bmem [int];

   always #2 clk = ~clk;   // 250 MHz

   seg_byte_sequencer u_seg_byte_sequencer (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_word  (req_word),
      .req_seg   (req_seg),
      .req_off   (req_off),
      .req_wdata (req_wdata),
      .rsp_done  (rsp_done),
      .rsp_rdata (rsp_rdata),
      .mem_addr  (mem_addr),
      .mem_ale   (mem_ale),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   function automatic logic [7:0] peek(input int a);
      if (bmem.exists(a)) return bmem[a];
      return 8'(a ^ (a >> 8) ^ 8'h5A);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // One transfer, compared clock by clock against the behavioural model.
   // keep=1 leaves req_valid high and moves req_seg to nseg during the transfer.
   task automatic run_req(input bit wr, input bit word, input logic [15:0] seg,
                          input logic [15:0] off, input logic [15:0] wd,
                          input bit keep, input logic [15:0] nseg);
      int pa;
      int n;
      int exp_r;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_word  = word;
      req_seg   = seg;
      req_off   = off;
      req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      if (keep) req_seg = nseg;
      else req_valid = 1'b0;
      pa = ((int'(seg) << 4) + int'(off)) & 32'hFFFFF;
      n = word ? 2 : 1;
      exp_r = 0;
      for (int b = 0; b < n; b++) begin
         int a;
         logic [7:0] eb;
         a = (pa + b) & 32'hFFFFF;
         // latch clock
         chk(mem_ale == 1'b1 && mem_rd == 1'b0 && mem_wr == 1'b0, "R6 ale", {mem_ale, mem_rd, mem_wr}, 3'b100);
         chk(int'(mem_addr) == a, b == 0 ? "R1 address" : "R2 second address", mem_addr, a);
         chk(req_ready == 1'b0 && rsp_done == 1'b0, "R7 busy", {req_ready, rsp_done}, 0);
         @(negedge clk);
         // strobe clock
         chk(mem_ale == 1'b0 && mem_rd == !wr && mem_wr == wr, "R6 strobe", {mem_ale, mem_rd, mem_wr}, {1'b0, !wr, wr});
         chk(int'(mem_addr) == a, "R10 hold strobe", mem_addr, a);
         if (wr) begin
            eb = 8'(wd >> (8 * b));
            chk(mem_wdata == eb, word ? "R3 write lane" : "R5 byte write", mem_wdata, eb);
            bmem[a] = eb;
         end else begin
            eb = peek(a);
            mem_rdata = eb;
            exp_r = exp_r | (int'(eb) << (8 * b));
         end
         @(negedge clk);
         // quiet clock
         mem_rdata = 8'hC3;
         chk(mem_ale == 1'b0 && mem_rd == 1'b0 && mem_wr == 1'b0, "R6 quiet", {mem_ale, mem_rd, mem_wr}, 0);
         chk(int'(mem_addr) == a, "R10 hold quiet", mem_addr, a);
         chk(rsp_done == (b == n - 1), "R8 done", rsp_done, (b == n - 1));
         if (!wr && b == n - 1)
            chk(int'(rsp_rdata) == exp_r, "R4 read data", rsp_rdata, exp_r);
         @(negedge clk);
      end
      chk(req_ready == 1'b1 && rsp_done == 1'b0 && mem_ale == 1'b0, "R5 R8 back to idle",
          {req_ready, rsp_done, mem_ale}, 3'b100);
   endtask

   initial begin
      #1;
      chk(req_ready == 1'b1 && mem_ale == 1'b0 && mem_rd == 1'b0 && mem_wr == 1'b0 && rsp_done == 1'b0,
          "R9 reset", {req_ready, mem_ale, mem_rd, mem_wr, rsp_done}, 5'b10000);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(req_ready == 1'b1 && rsp_done == 1'b0, "R9 after reset", {req_ready, rsp_done}, 2'b10);

      // R1 R3: word write at A000:5F00 -> A5F00 low, A5F01 high
      run_req(1'b1, 1'b1, 16'hA000, 16'h5F00, 16'h1234, 1'b0, 16'h0);
      // R4: word read back
      run_req(1'b0, 1'b1, 16'hA000, 16'h5F00, 16'h0000, 1'b0, 16'h0);
      // R5: byte write ignores upper data byte, then byte read (R4 upper zero)
      run_req(1'b1, 1'b0, 16'h1234, 16'h0005, 16'h77AB, 1'b0, 16'h0);
      run_req(1'b0, 1'b0, 16'h1234, 16'h0005, 16'h0000, 1'b0, 16'h0);
      run_req(1'b0, 1'b0, 16'h1234, 16'h0006, 16'h0000, 1'b0, 16'h0);
      // R4: word read straddling a written and an untouched byte
      run_req(1'b0, 1'b1, 16'h1234, 16'h0004, 16'h0000, 1'b0, 16'h0);
      // R2: second byte wraps FFFFF -> 00000
      run_req(1'b1, 1'b1, 16'hF000, 16'hFFFF, 16'hBEEF, 1'b0, 16'h0);
      run_req(1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0);
      run_req(1'b0, 1'b1, 16'hF000, 16'hFFFF, 16'h0000, 1'b0, 16'h0);
      // R1: segment plus offset carry dropped, FFFF:0010 -> 00000
      run_req(1'b0, 1'b1, 16'hFFFF, 16'h0010, 16'h0000, 1'b0, 16'h0);
      // R7: request fields change while busy, valid held; next accepted at idle
      run_req(1'b1, 1'b1, 16'h2000, 16'h0100, 16'hCAFE, 1'b1, 16'h3000);
      run_req(1'b1, 1'b1, 16'h3000, 16'h0100, 16'hCAFE, 1'b0, 16'h0);
      run_req(1'b0, 1'b1, 16'h2000, 16'h0100, 16'h0000, 1'b0, 16'h0);
      run_req(1'b0, 1'b1, 16'h3000, 16'h0100, 16'h0000, 1'b0, 16'h0);
      // odd address word, mixed pattern
      run_req(1'b1, 1'b1, 16'h0FFF, 16'hFFF3, 16'h5AA5, 1'b0, 16'h0);
      run_req(1'b0, 1'b1, 16'h0FFF, 16'hFFF3, 16'h0000, 1'b0, 16'h0);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule